// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a synchronous front end that gives an on-chip requester read and write access to an external asynchronous static RAM of 65,536 sixteen-bit words. The requester presents one access at a time on a valid/ready handshake: a word address, write data, a direction flag and one enable bit per byte lane. The controller turns each accepted request into a timed pin sequence on the SRAM side. That side has active-low chip select, write strobe, output enable and per-lane enables, plus a bidirectional data bus that is split into out, drive-enable and in signals.

The length of each strobe is a whole number of clock cycles. It is derived from the clock period and the memory access time, both given as parameters, so that access and pulse-width times are met. All SRAM-side outputs come from flops, which keeps the pins free of glitches. Write strobes end with every enable rising in the same cycle. Address and data are then held for one more cycle. The data driver is always off during, and in the cycle before, any cycle in which the memory may drive the bus. Read data comes back as a one-cycle response pulse. Lanes that were not enabled read as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no SRAM access is in progress. It is low from the cycle after a request with at least one lane enabled is taken until that access has finished, and it is never high while `sram_ce_n` is low.
- R2: A write holds `sram_ce_n` and `sram_we_n` low together for exactly W cycles. W is the access time divided by the clock period, rounded up, with a minimum of 1; the defaults of 10 ns and 5 ns give W = 2. During those cycles the address and the write data on `sram_dq_o` are stable, `sram_dq_oe` is high and `sram_oe_n` is high.
- R3: Bit 0 of `req_be` selects the low byte (data bits 7:0) and drives `sram_lb_n` low. Bit 1 selects the high byte (bits 15:8) and drives `sram_ub_n` low. A write changes only the bytes whose lane bit is set.
- R4: A write strobe ends with `sram_we_n`, `sram_ce_n`, `sram_ub_n` and `sram_lb_n` all rising in the same cycle. In that cycle `sram_addr` and `sram_dq_o` keep the values they had during the strobe, and `sram_dq_oe` stays high.
- R5: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for exactly W cycles. The address is valid from the first of these cycles and stays stable until the read ends.
- R6: `sram_dq_oe` is low in every cycle where `sram_oe_n` is low, and it is low in the cycle just before `sram_oe_n` falls.
- R7: A read answers with `rsp_valid` high for one cycle, in the cycle after its last strobe cycle. `rsp_rdata` holds the bus value sampled at the end of that last cycle, with every byte whose lane bit was clear forced to zero.
- R8: A request with `req_be` = 2'b00 starts no SRAM cycle: `sram_ce_n` stays high and `req_ready` stays high. A read of this kind gives `rsp_valid` with `rsp_rdata` = 0 in the cycle after it is taken, and a write of this kind leaves the memory unchanged.
- R9: During reset and right after it, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are high, `sram_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 16 | SRAM address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | High-byte lane enable, active low |
| sram_lb_n | output | 1 | Low-byte lane enable, active low |
| sram_dq_o | output | 16 | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable of the data bus |
| sram_dq_i | input | 16 | Data received from the SRAM |

## Verification
The bench uses a memory model that drives filler bytes on disabled lanes and on a deselected bus. A controller that failed to mask lanes, or that sampled too early, would therefore return that filler in place of the expected bytes. The model commits a write only when the strobe closes, and it checks the strobe length, simultaneous enable release, and address and data hold in that cycle. A design that dropped the hold cycle, or released the lane enables late, would store the wrong data or be flagged at the rising edge. Write-then-read to one address back to back tests the bus turnaround, since a driver left on while the output enable falls shows up as contention. Empty requests are checked both for a missing SRAM cycle and for an untouched word on a later read.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_HOLD  = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        logic [LANES-1:0]  be;
    } req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dq;
        logic              dq_oe;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  lane_n;
    } pins_t;

    // Strobe length in cycles: access time over clock period, rounded up, at least one.
    function automatic int wait_cycles(input int clk_ps, input int acc_ps);
        int n;
        n = (acc_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
        end
        return m;
    endfunction

    // Pin image for a phase and the command it serves.
    function automatic pins_t pins_for(input phase_e ph, input req_t c);
        pins_t p;
        p.addr   = c.addr;
        p.dq     = c.wdata;
        p.dq_oe  = 1'b0;
        p.ce_n   = 1'b1;
        p.we_n   = 1'b1;
        p.oe_n   = 1'b1;
        p.lane_n = '1;
        case (ph)
            PH_WRITE: begin
                p.ce_n   = 1'b0;
                p.we_n   = 1'b0;
                p.dq_oe  = 1'b1;
                p.lane_n = ~c.be;
            end
            PH_HOLD: begin
                p.dq_oe  = 1'b1;
            end
            PH_READ: begin
                p.ce_n   = 1'b0;
                p.oe_n   = 1'b0;
                p.lane_n = ~c.be;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  req_t             req_in,
    output logic             req_ready,
    output phase_e           phase_d,
    output req_t             cmd_d,
    output logic [LANES-1:0] cmd_be_q,
    output logic             rd_done,
    output logic             empty_rd
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    phase_e           phase_q;
    req_t             cmd_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;
    logic             empty;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign empty     = (req_in.be == '0);
    assign rd_done   = (phase_q == PH_READ) && (cnt_q == '0);
    assign empty_rd  = accept && empty && !req_in.we;
    assign cmd_be_q  = cmd_q.be;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        cmd_d   = cmd_q;
        case (phase_q)
            PH_IDLE: begin
                if (accept && !empty) begin
                    cmd_d   = req_in;
                    cnt_d   = CNT_LAST;
                    phase_d = req_in.we ? PH_WRITE : PH_READ;
                end
            end
            PH_WRITE: begin
                if (cnt_q == '0) phase_d = PH_HOLD;
                else             cnt_d   = cnt_q - 1'b1;
            end
            PH_HOLD: begin
                phase_d = PH_IDLE;
            end
            PH_READ: begin
                if (cnt_q == '0) phase_d = PH_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            cmd_q   <= cmd_d;
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_in.be != '0) |=> !req_ready); // R1

    AST_EMPTY_STAYS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_in.be == '0) |=> req_ready); // R8

endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
    import sram_lane_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_d,
    input  req_t   cmd_d,
    output pins_t  pins_q
);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= pins_for(PH_IDLE, '0);
        else     pins_q <= pins_for(phase_d, cmd_d);
    end

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !pins_q.oe_n |-> !pins_q.dq_oe); // R6

    AST_RELEASE_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.oe_n) |-> !$past(pins_q.dq_oe)); // R6

    AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> (!pins_q.ce_n && pins_q.oe_n && pins_q.dq_oe)); // R2

    AST_WR_END_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.we_n) |-> (pins_q.ce_n && pins_q.lane_n == '1)); // R4

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.we_n) |-> (pins_q.dq_oe && $stable(pins_q.addr) && $stable(pins_q.dq))); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.ce_n && !$past(pins_q.ce_n)) |-> $stable(pins_q.addr)); // R5

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic              empty_rd,
    input  logic [LANES-1:0]  rd_be,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_done || empty_rd;
            if (rd_done)       rsp_rdata <= dq_i & lane_mask(rd_be);
            else if (empty_rd) rsp_rdata <= '0;
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_PS    = 5000,
    parameter int ACCESS_PS = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_we,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int WAIT_CYC = wait_cycles(CLK_PS, ACCESS_PS);

    req_t             req_in;
    req_t             cmd_d;
    phase_e           phase_d;
    logic [LANES-1:0] cmd_be_q;
    logic             rd_done;
    logic             empty_rd;
    pins_t            pins_q;

    assign req_in.addr  = req_addr;
    assign req_in.wdata = req_wdata;
    assign req_in.we    = req_we;
    assign req_in.be    = req_be;

    sram_lane_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .phase_d   (phase_d),
        .cmd_d     (cmd_d),
        .cmd_be_q  (cmd_be_q),
        .rd_done   (rd_done),
        .empty_rd  (empty_rd)
    );

    sram_lane_pins u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .cmd_d   (cmd_d),
        .pins_q  (pins_q)
    );

    sram_lane_rdcap u_rdcap (
        .clk       (clk),
        .rst       (rst),
        .rd_done   (rd_done),
        .empty_rd  (empty_rd),
        .rd_be     (cmd_be_q),
        .dq_i      (sram_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign sram_addr  = pins_q.addr;
    assign sram_ce_n  = pins_q.ce_n;
    assign sram_we_n  = pins_q.we_n;
    assign sram_oe_n  = pins_q.oe_n;
    assign sram_lb_n  = pins_q.lane_n[0];
    assign sram_ub_n  = pins_q.lane_n[LANES-1];
    assign sram_dq_o  = pins_q.dq;
    assign sram_dq_oe = pins_q.dq_oe;

    AST_CE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !req_ready); // R1

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> rsp_valid); // R7

    AST_UPPER_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(sram_ub_n)) |-> (rsp_rdata[DATA_W-1:LANE_W] == '0)); // R7

    AST_LOWER_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(sram_lb_n)) |-> (rsp_rdata[LANE_W-1:0] == '0)); // R7

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/100ps
module sram_lane_ctrl_tb;

    localparam int CLK_PERIOD = 5;       // ns
    localparam int EXP_WAIT   = 2;       // 10 ns access over a 5 ns clock

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    int checks = 0;
    int errors = 0;

    logic [15:0] mdl_mem [256];
    logic [15:0] mdl_tag [256];
    logic [15:0] exp_mem [256];

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    sram_lane_ctrl #(.CLK_PS(CLK_PERIOD * 1000), .ACCESS_PS(10000)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    function automatic logic [15:0] addr_of(input logic [7:0] idx);
        logic [7:0] hi;
        hi = (idx * 8'd37) ^ 8'h5C;
        return {hi, idx};
    endfunction

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'h1234;
    endfunction

    function automatic logic [15:0] mask_of(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: disabled lanes and a deselected bus return filler bytes.
    always_comb begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n && !(sram_ub_n && sram_lb_n)) begin
            sram_dq_i[15:8] = sram_ub_n ? 8'hA5 : mdl_mem[sram_addr[7:0]][15:8];
            sram_dq_i[7:0]  = sram_lb_n ? 8'h5A : mdl_mem[sram_addr[7:0]][7:0];
        end else begin
            sram_dq_i = 16'hC3C3;
        end
    end

    int          wr_len, rd_len;
    logic [15:0] p_addr, p_dq;
    logic        p_ub_n, p_lb_n, p_oe_n, p_dq_oe;

    always @(negedge clk) begin
        if (rst) begin
            wr_len = 0; rd_len = 0;
            p_addr = '0; p_dq = '0; p_ub_n = 1'b1; p_lb_n = 1'b1; p_oe_n = 1'b1; p_dq_oe = 1'b0;
        end else begin
            if (!sram_ce_n && !sram_we_n) begin
                if (wr_len > 0)
                    chk(sram_addr == p_addr && sram_dq_o == p_dq, "R2 write addr/data stable",
                        {sram_addr, sram_dq_o}, {p_addr, p_dq});
                chk(sram_dq_oe && sram_oe_n, "R2 write drive on, oe off", {sram_dq_oe, sram_oe_n}, 2'b11);
                wr_len++;
            end else if (wr_len > 0) begin
                chk(wr_len == EXP_WAIT, "R2 write strobe length", wr_len, EXP_WAIT);
                chk(sram_ce_n && sram_we_n && sram_ub_n && sram_lb_n, "R4 enables rise together",
                    {sram_ce_n, sram_we_n, sram_ub_n, sram_lb_n}, 4'hF);
                chk(sram_dq_oe && sram_addr == p_addr && sram_dq_o == p_dq, "R4 hold cycle",
                    {sram_dq_oe, sram_addr, sram_dq_o}, {1'b1, p_addr, p_dq});
                if (!p_lb_n) mdl_mem[p_addr[7:0]][7:0]  = p_dq[7:0];
                if (!p_ub_n) mdl_mem[p_addr[7:0]][15:8] = p_dq[15:8];
                mdl_tag[p_addr[7:0]] = p_addr;
                wr_len = 0;
            end
            if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
                if (rd_len > 0)
                    chk(sram_addr == p_addr, "R5 read addr stable", sram_addr, p_addr);
                chk(mdl_tag[sram_addr[7:0]] == sram_addr, "R5 read address",
                    sram_addr, mdl_tag[sram_addr[7:0]]);
                rd_len++;
            end else if (rd_len > 0) begin
                chk(rd_len == EXP_WAIT, "R5 read strobe length", rd_len, EXP_WAIT);
                rd_len = 0;
            end
            if (!sram_oe_n)
                chk(!sram_dq_oe, "R6 driver off while oe low", sram_dq_oe, 1'b0);
            if (!sram_oe_n && p_oe_n)
                chk(!p_dq_oe, "R6 driver off before oe falls", p_dq_oe, 1'b0);
            if (!sram_ce_n)
                chk(!req_ready, "R1 not ready during access", req_ready, 1'b0);
            p_addr = sram_addr; p_dq = sram_dq_o; p_ub_n = sram_ub_n; p_lb_n = sram_lb_n;
            p_oe_n = sram_oe_n; p_dq_oe = sram_dq_oe;
        end
    end

    task automatic wait_ready();
        int n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [15:0] d, input logic [1:0] be);
        wait_ready();
        req_valid = 1'b1; req_addr = addr_of(idx); req_wdata = d; req_we = 1'b1; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        if (be[0]) exp_mem[idx][7:0]  = d[7:0];
        if (be[1]) exp_mem[idx][15:8] = d[15:8];
        if (be == 2'b00) begin
            chk(sram_ce_n && req_ready, "R8 empty write no cycle", {sram_ce_n, req_ready}, 2'b11);
        end else begin
            chk(!req_ready, "R1 busy after write taken", req_ready, 1'b0);
            wait_ready();
        end
    endtask

    task automatic do_read(input logic [7:0] idx, input logic [1:0] be);
        int n;
        logic [15:0] exp;
        wait_ready();
        req_valid = 1'b1; req_addr = addr_of(idx); req_we = 1'b0; req_be = be; req_wdata = 16'hFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (be == 2'b00)
            chk(sram_ce_n && req_ready, "R8 empty read no cycle", {sram_ce_n, req_ready}, 2'b11);
        else
            chk(!req_ready, "R1 busy after read taken", req_ready, 1'b0);
        while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
        exp = exp_mem[idx] & mask_of(be);
        chk(n == ((be == 2'b00) ? 1 : EXP_WAIT + 1), "R7 response latency", n,
            (be == 2'b00) ? 1 : EXP_WAIT + 1);
        chk(rsp_rdata == exp, (be == 2'b00) ? "R8 empty read data" : "R7 read data masked", rsp_rdata, exp);
        @(negedge clk);
        chk(!rsp_valid, "R7 single-cycle response", rsp_valid, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mdl_mem[i] = init_val(i);
            exp_mem[i] = init_val(i);
            mdl_tag[i] = addr_of(8'(i));
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n, "R9 strobes idle in reset",
            {sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 5'h1F);
        chk(!sram_dq_oe && req_ready && !rsp_valid, "R9 drive/ready/rsp in reset",
            {sram_dq_oe, req_ready, rsp_valid}, 3'b010);
        rst = 1'b0;
        @(negedge clk);
        chk(sram_ce_n && !sram_dq_oe && req_ready && !rsp_valid, "R9 idle after reset",
            {sram_ce_n, sram_dq_oe, req_ready, rsp_valid}, 4'b1010);

        // Directed lane cases (R3)
        do_write(8'd1, 16'hBEEF, 2'b11);
        do_read(8'd1, 2'b11);
        do_write(8'd1, 16'h1177, 2'b01);
        do_read(8'd1, 2'b11);                 // R3 upper byte kept
        do_write(8'd1, 16'h2299, 2'b10);
        do_read(8'd1, 2'b11);                 // R3 lower byte kept
        do_read(8'd1, 2'b01);                 // R7 upper forced zero
        do_read(8'd1, 2'b10);                 // R7 lower forced zero
        // Empty requests (R8)
        do_write(8'd1, 16'h0000, 2'b00);
        do_read(8'd1, 2'b11);
        do_read(8'd2, 2'b00);
        do_read(8'd2, 2'b00);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[6]) do_write({4'd0, r[3:0]}, 16'($urandom), r[5:4]);
            else      do_read({4'd0, r[3:0]}, r[5:4]);
        end
        for (int i = 0; i < 16; i++) do_read(8'(i), 2'b11);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule